// File: doc/BRIEF.md
# Precise Exception Pipeline Control

This block is the control path of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that keeps exceptions precise. It owns the fetch program counter. Every pipeline latch carries a valid bit, the PC of its instruction, a fault mark and a cause code. Each of the first four stages can report a fault against the instruction it holds. That report is stored with the instruction and is not acted on when it is seen.

An exception is taken only when a fault-marked instruction sits in writeback. In that cycle the block raises a redirect strobe and cancels every younger instruction. On the next edge it loads the fetch PC with a fixed vector, saves the faulting PC and its cause, and empties all pipeline latches. An external interrupt request replaces the instruction being fetched with a fault-marked no-op, so interrupts are ordered with the program like any other fault.

From the first fault mark until the exception is taken, the block withholds register-file and memory write permission from the faulting instruction and from everything younger than it. The datapath itself is outside this block.

Top module: `exc_pipe_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, fetch_pc_o equals RESET_PC, stage_valid_o is 5'b00001, epc_o and cause_o are zero, and exc_take_o is low.
- R2: When no exception is taken and irq_i is low, fetch_pc_o advances by INSN_BYTES on every clock.
- R3: Cause codes are 0 for an interrupt, 1 for a fetch address fault, 2 for an illegal opcode, 3 for an arithmetic overflow and 4 for a data address fault. stage_fault_i bit k (0 fetch, 1 decode, 2 execute, 3 memory) gives cause k+1. When one instruction collects several faults, the cause of the earliest stage is kept.
- R4: exc_take_o is high exactly in the cycles where writeback holds a valid fault-marked instruction. In those cycles redirect_pc_o equals VECTOR.
- R5: One cycle after exc_take_o, fetch_pc_o equals VECTOR and epc_o/cause_o hold the PC and cause of the instruction that was in writeback. The exception of the older instruction is taken even if a younger one faulted first. Between exceptions, epc_o and cause_o do not change.
- R6: stage_valid_o bit k (0 fetch to 4 writeback) is low for stages 0 to 3 in a cycle with exc_take_o. In the following cycle, stages 1 to 4 are all invalid.
- R7: stage_wr_en_o bit k is high only if stage k is valid and no stage from k to 4 holds a fault-marked instruction or reports a fault this cycle. A pending interrupt counts as a fault at stage 0. A fault-marked instruction in writeback has no register write.
- R8: With irq_i high at a clock edge and no exception taken, a no-op carrying cause 0 and the current fetch PC enters decode, and fetch_pc_o holds its value.
- R9: A fault reported against an invalid stage has no effect: it never leads to exc_take_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | External interrupt request, sampled at fetch |
| stage_fault_i | input | 4 | Fault report per stage, bit 0 fetch to bit 3 memory |
| fetch_pc_o | output | PC_W | PC of the instruction being fetched |
| exc_take_o | output | 1 | Exception is taken this cycle (redirect strobe) |
| redirect_pc_o | output | PC_W | Redirect target |
| epc_o | output | PC_W | Saved PC of the last exception |
| cause_o | output | 3 | Cause of the last exception |
| stage_valid_o | output | 5 | Valid bit per stage, bit 0 fetch to bit 4 writeback |
| stage_wr_en_o | output | 5 | Write permission per stage |

## Verification
exc_take_o, redirect_pc_o, stage_valid_o and stage_wr_en_o are combinational in the cycle a condition holds. A fault reported at stage k turns into exc_take_o 4-k cycles later. fetch_pc_o, epc_o and cause_o change one cycle after exc_take_o. The bench applies inputs on the falling edge and compares every output 1 ns later against a reference model. The model advances only after the following rising edge, so each expected value belongs to the cycle it is sampled in. Directed sequences, with hand-computed cycle numbers, cover ordering, repeated faults on one instruction, interrupt hold and faults on bubbles. A long random phase follows them.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int N_STAGES = 5;
  localparam int N_FAULT  = N_STAGES - 1;
  localparam int CAUSE_W  = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ     = 3'd0,
    CAUSE_IADDR   = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DADDR   = 3'd4
  } cause_e;

  // cause reported by a fault raised in pipeline stage 'stage'
  function automatic cause_e fault_cause(int stage);
    case (stage)
      0:       return CAUSE_IADDR;
      1:       return CAUSE_ILLEGAL;
      2:       return CAUSE_OVF;
      default: return CAUSE_DADDR;
    endcase
  endfunction
endpackage

// File: rtl/exc_fetch_pc.sv
`timescale 1ns/1ps
module exc_fetch_pc #(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] VECTOR     = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            irq_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    if (take_i)     pc_d = VECTOR;
    else if (irq_i) pc_d = pc_q;   // slot consumed by injected no-op
    else            pc_d = pc_q + PC_W'(INSN_BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/exc_stage_latch.sv
`timescale 1ns/1ps
module exc_stage_latch
  import exc_pkg::*;
#(
  parameter int     PC_W        = 32,
  parameter cause_e FAULT_CAUSE = CAUSE_IADDR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            exc_i,
  input  cause_e          cause_i,
  input  logic            fault_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o,
  output logic            exc_o,
  output cause_e          cause_o
);
  logic            valid_q, exc_q;
  logic [PC_W-1:0] pc_q;
  cause_e          cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      pc_q    <= '0;
      cause_q <= CAUSE_IRQ;
    end else begin
      valid_q <= valid_i & ~flush_i;
      if (valid_i) begin
        pc_q    <= pc_i;
        exc_q   <= exc_i | fault_i;
        // first mark wins: an earlier stage's cause is never overwritten
        cause_q <= exc_i ? cause_i : FAULT_CAUSE;
      end
    end
  end

  assign valid_o = valid_q;
  assign pc_o    = pc_q;
  assign exc_o   = exc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/exc_wr_guard.sv
`timescale 1ns/1ps
module exc_wr_guard #(
  parameter int N = 5
) (
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] mark_i,
  output logic [N-1:0] wr_en_o
);
  // older[k]: some stage at k or beyond (older) is fault-marked
  logic [N:0] older;
  assign older[N] = 1'b0;

  for (genvar k = N - 1; k >= 0; k--) begin : g_chain
    assign older[k]   = older[k+1] | mark_i[k];
    assign wr_en_o[k] = valid_i[k] & ~older[k];
  end
endmodule

// File: rtl/exc_commit.sv
`timescale 1ns/1ps
module exc_commit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          cause_i,
  output logic [PC_W-1:0] epc_o,
  output cause_e          cause_o
);
  logic [PC_W-1:0] epc_q;
  cause_e          cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= CAUSE_IRQ;
    end else if (take_i) begin
      epc_q   <= pc_i;
      cause_q <= cause_i;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/exc_pipe_ctrl.sv
`timescale 1ns/1ps
module exc_pipe_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_0100,
  parameter logic [PC_W-1:0] VECTOR     = 32'h0000_0080
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                irq_i,
  input  logic [N_FAULT-1:0]  stage_fault_i,
  output logic [PC_W-1:0]     fetch_pc_o,
  output logic                exc_take_o,
  output logic [PC_W-1:0]     redirect_pc_o,
  output logic [PC_W-1:0]     epc_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [N_STAGES-1:0] stage_valid_o,
  output logic [N_STAGES-1:0] stage_wr_en_o
);
  localparam int N_ST = N_STAGES;
  localparam int WB   = N_ST - 1;

  logic [PC_W-1:0] fetch_pc;
  logic [N_ST-1:0] s_valid, s_exc, s_mark;
  logic [PC_W-1:0] s_pc    [N_ST];
  cause_e          s_cause [N_ST];
  logic            take;
  cause_e          last_cause;

  exc_fetch_pc #(
    .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC), .VECTOR(VECTOR)
  ) i_fetch_pc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .irq_i (irq_i),
    .pc_o  (fetch_pc)
  );

  // fetch slot: an interrupt turns it into a fault-marked no-op
  assign s_valid[0] = 1'b1;
  assign s_pc[0]    = fetch_pc;
  assign s_exc[0]   = irq_i;
  assign s_cause[0] = CAUSE_IRQ;

  for (genvar k = 1; k < N_ST; k++) begin : g_latch
    exc_stage_latch #(
      .PC_W(PC_W), .FAULT_CAUSE(fault_cause(k - 1))
    ) i_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(take),
      .valid_i(s_valid[k-1]),
      .pc_i   (s_pc[k-1]),
      .exc_i  (s_exc[k-1]),
      .cause_i(s_cause[k-1]),
      .fault_i(stage_fault_i[k-1]),
      .valid_o(s_valid[k]),
      .pc_o   (s_pc[k]),
      .exc_o  (s_exc[k]),
      .cause_o(s_cause[k])
    );
  end

  // a stage is marked if it carries a fault or reports one now
  for (genvar k = 0; k < WB; k++) begin : g_mark
    assign s_mark[k] = s_valid[k] & (s_exc[k] | stage_fault_i[k]);
  end
  assign s_mark[WB] = s_valid[WB] & s_exc[WB];

  assign take = s_mark[WB];

  exc_wr_guard #(.N(N_ST)) i_wr_guard (
    .valid_i(s_valid),
    .mark_i (s_mark),
    .wr_en_o(stage_wr_en_o)
  );

  exc_commit #(.PC_W(PC_W)) i_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .pc_i   (s_pc[WB]),
    .cause_i(s_cause[WB]),
    .epc_o  (epc_o),
    .cause_o(last_cause)
  );

  assign fetch_pc_o    = fetch_pc;
  assign exc_take_o    = take;
  assign redirect_pc_o = VECTOR;
  assign cause_o       = last_cause;
  assign stage_valid_o = {s_valid[WB], s_valid[WB-1:0] & ~{WB{take}}};
endmodule

// File: rtl/exc_pipe_ctrl_sva.sv
`timescale 1ns/1ps
module exc_pipe_ctrl_sva #(
  parameter int              PC_W       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [PC_W-1:0] VECTOR     = '0,
  parameter int              N_ST       = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_i,
  input logic [PC_W-1:0] fetch_pc_o,
  input logic            exc_take_o,
  input logic [PC_W-1:0] epc_o,
  input logic [2:0]      cause_o,
  input logic [N_ST-1:0] stage_valid_o,
  input logic [N_ST-1:0] stage_wr_en_o
);
  a_r5_fetch_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |=> fetch_pc_o == VECTOR);

  a_r5_record_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_take_o |=> $stable(epc_o) && $stable(cause_o));

  a_r6_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |=> stage_valid_o[N_ST-1:1] == '0);

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_take_o && !irq_i |=> fetch_pc_o == $past(fetch_pc_o) + PC_W'(INSN_BYTES));

  a_r8_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !exc_take_o |=> $stable(fetch_pc_o));

  a_r7_take_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |-> stage_wr_en_o == '0);

  a_r7_write_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_wr_en_o & ~stage_valid_o) == '0);
endmodule

bind exc_pipe_ctrl exc_pipe_ctrl_sva #(
  .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .VECTOR(VECTOR), .N_ST(exc_pkg::N_STAGES)
) i_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_i        (irq_i),
  .fetch_pc_o   (fetch_pc_o),
  .exc_take_o   (exc_take_o),
  .epc_o        (epc_o),
  .cause_o      (cause_o),
  .stage_valid_o(stage_valid_o),
  .stage_wr_en_o(stage_wr_en_o)
);

// File: tb/test_exc_pipe_ctrl.sv
`timescale 1ns/1ps
module test_exc_pipe_ctrl;
  localparam int          PC_W  = 32;
  localparam int          STEP  = 4;
  localparam logic [31:0] RST_A = 32'h0000_0100;
  localparam logic [31:0] VEC_A = 32'h0000_0080;
  localparam int          NCYC  = 3000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq = 1'b0;
  logic [3:0]  flt = '0;
  logic [31:0] fetch_pc, redir_pc, epc;
  logic        take;
  logic [2:0]  cause;
  logic [4:0]  svalid, swr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  exc_pipe_ctrl #(.PC_W(PC_W), .INSN_BYTES(STEP), .RESET_PC(RST_A), .VECTOR(VEC_A))
  i_exc_pipe_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .stage_fault_i(flt),
    .fetch_pc_o(fetch_pc), .exc_take_o(take), .redirect_pc_o(redir_pc),
    .epc_o(epc), .cause_o(cause), .stage_valid_o(svalid), .stage_wr_en_o(swr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: index 0 = fetch, 4 = writeback
  bit          m_v  [5];
  logic [31:0] m_pc [5];
  bit          m_ex [5];
  int          m_cs [5];
  logic [31:0] m_fpc, m_epc;
  int          m_cause;

  function automatic bit m_take();
    return m_v[4] && m_ex[4];
  endfunction

  task automatic compare_all();
    bit [4:0] e_val, e_wr, mark;
    bit older;
    bit t;
    t = m_take();
    for (int k = 0; k < 5; k++) begin
      if (k == 0)      mark[k] = irq || flt[0];
      else if (k < 4)  mark[k] = m_v[k] && (m_ex[k] || flt[k]);
      else             mark[k] = m_v[k] && m_ex[k];
      e_val[k] = (k == 0) ? !t : (k < 4 ? m_v[k] && !t : m_v[k]);
    end
    older = 0;
    for (int k = 4; k >= 0; k--) begin
      older = older || mark[k];
      e_wr[k] = (k == 0 ? 1'b1 : m_v[k]) && !older;
    end
    chk(fetch_pc == m_fpc, "R2", "fetch_pc", fetch_pc, m_fpc);
    chk(take == t, "R4", "exc_take", take, t);
    if (t) chk(redir_pc == VEC_A, "R4", "redirect_pc", redir_pc, VEC_A);
    chk(epc == m_epc, "R5", "epc", epc, m_epc);
    chk(cause == 3'(m_cause), "R3", "cause", cause, m_cause);
    chk(svalid == e_val, "R6", "stage_valid", svalid, e_val);
    chk(swr == e_wr, "R7", "stage_wr_en", swr, e_wr);
  endtask

  task automatic model_step();
    if (m_take()) begin
      m_epc   = m_pc[4];
      m_cause = m_cs[4];
      m_fpc   = VEC_A;
      for (int k = 1; k < 5; k++) m_v[k] = 0;
    end else begin
      for (int k = 4; k >= 2; k--) begin
        m_v[k]  = m_v[k-1];
        m_pc[k] = m_pc[k-1];
        m_cs[k] = m_ex[k-1] ? m_cs[k-1] : k;
        m_ex[k] = m_v[k-1] && (m_ex[k-1] || flt[k-1]);
      end
      m_v[1]  = 1;
      m_pc[1] = m_fpc;
      m_ex[1] = irq || flt[0];
      m_cs[1] = irq ? 0 : 1;
      if (!irq) m_fpc = m_fpc + STEP;
    end
  endtask

  task automatic stimulus(input int c);
    irq = 1'b0;
    flt = '0;
    case (c)
      2:  flt = 4'b0001;  // younger insn (0x108) faults at fetch
      3:  flt = 4'b1000;  // older insn (0x100) faults at memory
      6:  flt = 4'b1100;  // execute and memory hold bubbles (R9)
      12: irq = 1'b1;
      20: flt = 4'b0001;  // 0x8C faults at fetch ...
      22: flt = 4'b0100;  // ... and again at execute
      default: if (c >= 30) begin
        irq = ($urandom % 40) == 0;
        for (int b = 0; b < 4; b++) flt[b] = ($urandom % 12) == 0;
      end
    endcase
  endtask

  task automatic directed(input int c);
    case (c)
      3:  chk(swr == 5'b00000, "R7", "writes blocked behind fault", swr, 0);
      4:  chk(take == 1'b1, "R4", "take at writeback", take, 1);
      5: begin
        chk(fetch_pc == VEC_A, "R5", "vector fetch", fetch_pc, VEC_A);
        chk(epc == RST_A, "R5", "older insn wins epc", epc, RST_A);
        chk(cause == 3'd4, "R5", "older insn wins cause", cause, 4);
        chk(svalid == 5'b00001, "R6", "pipe emptied", svalid, 5'b00001);
      end
      8:  chk(take == 1'b0, "R9", "bubble fault ignored", take, 0);
      12: chk(swr == 5'b11110, "R8", "irq slot no write", swr, 5'b11110);
      13: chk(fetch_pc == 32'h9C, "R8", "fetch held on irq", fetch_pc, 32'h9C);
      17: begin
        chk(epc == 32'h9C, "R8", "irq epc", epc, 32'h9C);
        chk(cause == 3'd0, "R3", "irq cause", cause, 0);
      end
      25: begin
        chk(epc == 32'h8C, "R3", "double fault epc", epc, 32'h8C);
        chk(cause == 3'd1, "R3", "earliest stage cause", cause, 1);
      end
      default: ;
    endcase
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fetch_pc == RST_A, "R1", "reset fetch_pc", fetch_pc, RST_A);
    chk(svalid == 5'b00001, "R1", "reset valid", svalid, 5'b00001);
    chk(epc == 0, "R1", "reset epc", epc, 0);
    chk(cause == 0, "R1", "reset cause", cause, 0);
    chk(take == 0, "R1", "reset take", take, 0);
    m_fpc = RST_A; m_epc = '0; m_cause = 0;
    for (int k = 0; k < 5; k++) begin
      m_v[k] = 0; m_pc[k] = '0; m_ex[k] = 0; m_cs[k] = 0;
    end
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      if (c > 0) @(negedge clk);
      stimulus(c);
      #1;
      compare_all();
      directed(c);
      @(posedge clk);
      model_step();
    end
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule